// File: doc/BRIEF.md
# Condition Code Evaluator

This block turns a 4-bit condition selector and the five processor status flags into a single true/false answer. The flags are zero, sign, overflow, carry and the sticky saturation flag. A processor pipeline uses the answer in two ways. For a conditional branch, it is gated by a branch-mode strobe to give the taken decision. For the flag-to-register instruction, it is written as a full-width 0 or 1.

The block also sign-extends the short 9-bit branch displacement to the datapath width, so the branch adder downstream receives a ready operand. The parameter `REG_OUT` selects the output timing. With its default of 1, every output is registered and appears one clock after its inputs. With 0, the path is purely combinational.

All sixteen selector values are legal. The block has no illegal encoding, so no input value can drive an output to an unknown state.

Top module: `cond_eval_unit`

## Requirements
- R1: Selector values 0, 1, 2, 3 and 4 are true when, respectively, overflow is set, carry is set, zero is set, carry or zero is set, and sign is set.
- R2: Selector value 5 is true for every flag combination.
- R3: Selector value 6 is true when sign XOR overflow is 1. Selector value 7 is true when zero is 1 or (sign XOR overflow) is 1.
- R4: Selector values 8 to 12 are the logical inverses of selector values 0 to 4, taken in the same order.
- R5: Selector value 13 is true exactly when the saturation flag is set.
- R6: Selector values 14 and 15 are the logical inverses of selector values 6 and 7.
- R7: `set_result` equals 1 when the condition is true and 0 when it is false, with bits 31 down to 1 always zero. It does not depend on `branch_mode`.
- R8: `taken` is 1 only when `branch_mode` is 1 and the condition is true. It is 0 whenever `branch_mode` is 0.
- R9: `target_offset` is `disp_in` (9 bits, two's complement) sign-extended to 32 bits.
- R10: With `REG_OUT` = 1, all outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high, `taken`, `set_result` and `target_offset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_code | input | 4 | Condition selector |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_ov | input | 1 | Overflow flag |
| flag_cy | input | 1 | Carry flag |
| flag_sat | input | 1 | Sticky saturation flag |
| branch_mode | input | 1 | Marks the current operation as a conditional branch |
| disp_in | input | 9 | Signed branch displacement |
| taken | output | 1 | Branch taken decision |
| set_result | output | 32 | 0 or 1 value for the destination register |
| target_offset | output | 32 | Sign-extended displacement |

## Verification
On every cycle, the assertions check the following:
- the always-true selector;
- the zero and saturation selectors against the flags of the previous cycle;
- that `taken` never rises without a branch strobe or without a true `set_result`;
- that the low bits of the offset track the displacement.

The full truth table is shown only by the bench's scenarios. These are the inversion pairs, the signed compare forms built from sign XOR overflow, and the exhaustive sweep of every selector against all 32 flag patterns in both modes. The same holds for the sign extension of negative displacements and the reset values.

// File: rtl/ccev_pkg.sv
package ccev_pkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic sat;
    logic ov;
    logic s;
    logic z;
    logic cy;
  } psw_flags_t;

  // Index of the low-half entry whose upper-half partner is the
  // saturation test instead of an inversion.
  localparam logic [2:0] ALWAYS_IDX = 3'd5;
endpackage

// File: rtl/cond_logic.sv
module cond_logic
  import ccev_pkg::*;
(
  input  psw_flags_t         flags,
  input  logic [SEL_W-1:0]   sel,
  output logic               hit
);
  logic [7:0] base;
  logic       signed_lt;
  logic       picked;

  always_comb begin
    signed_lt = flags.s ^ flags.ov;
    base[0]   = flags.ov;
    base[1]   = flags.cy;
    base[2]   = flags.z;
    base[3]   = flags.cy | flags.z;
    base[4]   = flags.s;
    base[5]   = 1'b1;
    base[6]   = signed_lt;
    base[7]   = flags.z | signed_lt;
  end

  always_comb begin
    picked = base[sel[2:0]];
    if (!sel[3])
      hit = picked;
    else if (sel[2:0] == ALWAYS_IDX)
      hit = flags.sat;
    else
      hit = ~picked;
  end
endmodule

// File: rtl/disp_sext.sv
module disp_sext #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  disp,
  output logic [OUT_W-1:0] ext
);
  localparam int PAD_W = OUT_W - IN_W;
  assign ext = {{PAD_W{disp[IN_W-1]}}, disp};
endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
  import ccev_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DISP_W  = 9,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cond_code,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_ov,
  input  logic              flag_cy,
  input  logic              flag_sat,
  input  logic              branch_mode,
  input  logic [DISP_W-1:0] disp_in,
  output logic              taken,
  output logic [DATA_W-1:0] set_result,
  output logic [DATA_W-1:0] target_offset
);
  localparam int ZERO_W = DATA_W - 1;

  psw_flags_t        flags;
  logic              hit;
  logic              taken_d;
  logic [DATA_W-1:0] result_d;
  logic [DATA_W-1:0] offset_d;

  assign flags = '{sat: flag_sat, ov: flag_ov, s: flag_s, z: flag_z, cy: flag_cy};

  cond_logic u_cond (
    .flags (flags),
    .sel   (cond_code),
    .hit   (hit)
  );

  disp_sext #(.IN_W(DISP_W), .OUT_W(DATA_W)) u_sext (
    .disp (disp_in),
    .ext  (offset_d)
  );

  assign taken_d  = branch_mode & hit;
  assign result_d = {{ZERO_W{1'b0}}, hit};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          taken         <= 1'b0;
          set_result    <= '0;
          target_offset <= '0;
        end else begin
          taken         <= taken_d;
          set_result    <= result_d;
          target_offset <= offset_d;
        end
      end

      assert_always_true_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cond_code) == 4'd5) |-> set_result == 1);
      assert_zero_test_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cond_code) == 4'd2) |-> set_result[0] == $past(flag_z));
      assert_sat_test_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cond_code) == 4'd13) |-> set_result[0] == $past(flag_sat));
      assert_taken_gate_R8: assert property (@(posedge clk) disable iff (rst)
        taken |-> ($past(branch_mode) && set_result[0]));
      assert_offset_low_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> target_offset[DISP_W-1:0] == $past(disp_in));
    end else begin : g_comb
      assign taken         = taken_d;
      assign set_result    = result_d;
      assign target_offset = offset_d;

      always_comb begin
        assert_taken_gate_R8: assert (!taken || branch_mode);
      end
    end
  endgenerate
endmodule

// File: tb/test_cond_eval_unit.sv
`timescale 1ns/1ps
module test_cond_eval_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  cond_code;
  logic        flag_z, flag_s, flag_ov, flag_cy, flag_sat;
  logic        branch_mode;
  logic [8:0]  disp_in;
  logic        taken;
  logic [31:0] set_result;
  logic [31:0] target_offset;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cond_eval_unit i_cond_eval_unit (
    .clk(clk), .rst(rst), .cond_code(cond_code),
    .flag_z(flag_z), .flag_s(flag_s), .flag_ov(flag_ov),
    .flag_cy(flag_cy), .flag_sat(flag_sat),
    .branch_mode(branch_mode), .disp_in(disp_in),
    .taken(taken), .set_result(set_result), .target_offset(target_offset)
  );

  // flags vector: {sat, ov, s, z, cy}
  function automatic bit ref_cond(input logic [3:0] c, input logic [4:0] f);
    bit cy = f[0], z = f[1], s = f[2], ov = f[3], sat = f[4];
    case (c)
      4'd0:  return ov;
      4'd1:  return cy;
      4'd2:  return z;
      4'd3:  return cy | z;
      4'd4:  return s;
      4'd5:  return 1'b1;
      4'd6:  return s ^ ov;
      4'd7:  return z | (s ^ ov);
      4'd8:  return !ov;
      4'd9:  return !cy;
      4'd10: return !z;
      4'd11: return !(cy | z);
      4'd12: return !s;
      4'd13: return sat;
      4'd14: return !(s ^ ov);
      default: return !(z | (s ^ ov));
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c <= 4)  return "R1";
    if (c == 5)  return "R2";
    if (c <= 7)  return "R3";
    if (c <= 12) return "R4";
    if (c == 13) return "R5";
    return "R6";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, sample on the next falling edge (one register stage).
  task automatic apply(input logic [3:0] c, input logic [4:0] f, input bit mode, input logic [8:0] d);
    bit          e;
    logic [31:0] exp_off;
    @(negedge clk);
    cond_code = c;
    {flag_sat, flag_ov, flag_s, flag_z, flag_cy} = f;
    branch_mode = mode;
    disp_in = d;
    @(negedge clk);
    e = ref_cond(c, f);
    exp_off = {{23{d[8]}}, d};
    check(set_result == {31'd0, e}, req_of(c), set_result, {31'd0, e});
    check(set_result[31:1] == 0, "R7", set_result, {31'd0, e});
    check(taken == (mode & e), "R8", {31'd0, taken}, {31'd0, mode & e});
    check(target_offset == exp_off, "R9", target_offset, exp_off);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] dsv;
    void'($urandom(32'd1234));
    rst = 1'b1;
    cond_code = 4'd5;
    {flag_sat, flag_ov, flag_s, flag_z, flag_cy} = 5'h1f;
    branch_mode = 1'b1;
    disp_in = 9'h1ff;
    repeat (3) @(negedge clk);
    // R10: reset values hold even with active inputs
    check(taken == 1'b0, "R10", {31'd0, taken}, 32'd0);
    check(set_result == 32'd0, "R10", set_result, 32'd0);
    check(target_offset == 32'd0, "R10", target_offset, 32'd0);
    rst = 1'b0;

    // Exhaustive sweep: R1..R6 per code, both modes
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 16; c++)
        for (int f = 0; f < 32; f++) begin
          dsv = 9'($urandom);
          apply(4'(c), 5'(f), m[0], dsv);
        end

    // Directed displacement corners (R9)
    apply(4'd5, 5'd0, 1'b1, 9'h100);
    apply(4'd5, 5'd0, 1'b1, 9'h0ff);
    apply(4'd5, 5'd0, 1'b1, 9'h000);
    apply(4'd5, 5'd0, 1'b1, 9'h1ff);

    // R7: branch_mode has no effect on set_result; R8 false condition blocks taken
    apply(4'd13, 5'b10000, 1'b0, 9'd3);
    apply(4'd13, 5'b10000, 1'b1, 9'd3);
    apply(4'd13, 5'b01111, 1'b1, 9'd3);

    // Random mix
    for (int i = 0; i < 200; i++)
      apply(4'($urandom), 5'($urandom), 1'($urandom), 9'($urandom));

    // R10: one-cycle latency — output reflects previous edge, then reset clears it
    @(negedge clk);
    cond_code = 4'd5; branch_mode = 1'b1; disp_in = 9'h1f0;
    @(negedge clk);
    check(taken == 1'b1, "R10", {31'd0, taken}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    check(set_result == 32'd0, "R10", set_result, 32'd0);
    check(target_offset == 32'd0, "R10", target_offset, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule